// File: doc/BRIEF.md
# SPI Transmit Packet Loader

This block is an SPI master sequencer that hands one outgoing frame to a radio transceiver's transmit packet memory. A single start request carries the payload length; the payload bytes themselves are fetched on demand from a local byte buffer through a read-address port. The sequencer runs three chip-enable frames in a fixed order. The first reads the transceiver's 16-bit transmit-length register. The second writes that register back with only its length field replaced. The third is a single burst into packet memory.

Inside the burst the payload is sent as 16-bit words. Each word puts the odd-indexed byte on the wire before the even-indexed byte. An odd length is padded up to a whole word with a zero byte. The SPI side works in clock-idle-low mode: MOSI changes on falling edges and both sides sample on rising edges. The SCLK half period is a whole number of system clocks. Everything the transceiver returns on MISO during the two write frames is thrown away.

Top module: `txFrameLoader`

## Requirements
- R1: Command bytes are built from a 6-bit register address in bits 5:0, with bit 6 zero. Bit 7 is 1 for a read and 0 for a write. With the default parameters the length-register read command is 0x83, the write command is 0x03, and the packet-memory command is 0x02.
- R2: The first frame holds exactly three bytes: the read command, then two 0x00 dummy bytes. The MISO byte received during the first dummy becomes bits 15:8 of the old register value, and the byte received during the second becomes bits 7:0.
- R3: The second frame holds exactly three bytes: the write command, then the new value high byte first. The new value keeps bits 15:7 of the old value and sets bits 6:0 to (length + 2) modulo 128.
- R4: Between consecutive frames of one transaction, the chip enable stays high for at least 2*HALF_DIV clock cycles.
- R5: The third frame is one chip-enable window. It holds the packet-memory command followed by ceil(length/2) words, which is 1 + 2*ceil(length/2) bytes. A length of 0 sends the command byte alone.
- R6: Word k of the burst sends buffer byte 2k+1 and then buffer byte 2k. Every byte is shifted out most significant bit first.
- R7: When the length is odd, the high-byte position of the last word carries 0x00.
- R8: SCLK is low whenever the chip enable is high, and MOSI does not change at any SCLK rising edge.
- R9: A start request while busy is high is ignored. The running transaction keeps its latched length, and no extra frame follows it.
- R10: busy rises in the cycle after an accepted start. done is high for exactly one cycle, which is the first cycle with the chip enable high after the burst. busy is low in the cycle after done.
- R11: After reset, and whenever busy is low, the chip enable is high (spiCsN = 1) and SCLK is low. After reset, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request; accepted only while idle |
| frameLen | input | LEN_W | Payload length in bytes, latched at start |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| bufAddr | output | LEN_W | Byte index into the local buffer |
| bufData | input | 8 | Buffer byte at bufAddr, valid in the same cycle |
| spiCsN | output | 1 | Active-low chip enable |
| spiClk | output | 1 | SPI clock, idle low |
| spiMosi | output | 1 | Master data out |
| spiMiso | input | 1 | Slave data in |

## Verification
The loader is tried with payload lengths 0, 1, 2, 5, 8, 126 and 127. Each length is paired with a different old register value: all ones, all zeros and mixed patterns.

Length 0 checks that an empty burst still sends its command byte. Lengths 1 and 5 check the zero pad in the last high-byte position. Lengths 2 and 8 check the byte swap inside whole words. Length 126 makes length + 2 wrap the 7-bit field to zero. Length 127 reaches the top buffer index. The old register values show whether bits 15:7 survive the write-back untouched.

A second start with a different length is raised in the middle of a transaction. This tells whether the latched length is really protected from a request that arrives while busy is high.

// File: rtl/txLoaderPkg.sv
package txLoaderPkg;

  // Which byte the serializer loads when a byte transfer starts
  typedef enum logic [2:0] {
    SEL_RDCMD,
    SEL_WRCMD,
    SEL_RAMCMD,
    SEL_DUMMY,
    SEL_REGHI,
    SEL_REGLO,
    SEL_BUFHI,
    SEL_BUFLO
  } txSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   latchLen;
    logic   clrWord;
    logic   nextWord;
    logic   startByte;
    txSel_e sel;
    logic   capHi;
    logic   capLo;
    logic   ceOn;
    logic   ceOff;
  } ctrlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic byteDone;
    logic lastWord;
    logic emptyFrame;
  } dpStatus_t;

endpackage

// File: rtl/txLoaderDatapath.sv
module txLoaderDatapath
  import txLoaderPkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W = 7,
  parameter logic [5:0] LEN_REG_ADDR = 6'h03,
  parameter logic [5:0] RAM_ADDR = 6'h02
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [LEN_W-1:0] frameLen,
  output dpStatus_t        status,
  output logic [LEN_W-1:0] bufAddr,
  input  logic [7:0]       bufData,
  output logic             spiCsN,
  output logic             spiClk,
  output logic             spiMosi,
  input  logic             spiMiso
);

  localparam int IDX_W = LEN_W - 1;
  localparam logic [15:0] LEN_MASK = 16'((32'd1 << LEN_W) - 1);

  logic [LEN_W-1:0] lenR;
  logic [IDX_W-1:0] wordIdx;
  logic [IDX_W-1:0] curIdx;
  logic [LEN_W-1:0] hiIdx;
  logic [LEN_W-1:0] loIdx;
  logic             padHi;
  logic [15:0]      regWord;
  logic [15:0]      newReg;
  logic [LEN_W-1:0] lenPlus2;
  logic [LEN_W:0]   wordsTotal;
  logic [7:0]       txByte;

  logic       csNR;
  logic       sclkR;
  logic [3:0] edgeCnt;
  logic [7:0] txSh;
  logic [7:0] rxSh;
  logic       byteBusy;
  logic       byteDoneR;
  logic       halfTick;

  // Word index as seen by the byte being started now
  always_comb begin
    curIdx     = strobe.nextWord ? wordIdx + IDX_W'(1) : wordIdx;
    hiIdx      = {curIdx, 1'b1};
    loIdx      = {curIdx, 1'b0};
    bufAddr    = (strobe.sel == SEL_BUFHI) ? hiIdx : loIdx;
    padHi      = (hiIdx == lenR);
    lenPlus2   = lenR + LEN_W'(2);
    newReg     = (regWord & ~LEN_MASK) | 16'(lenPlus2);
    wordsTotal = ({1'b0, lenR} + (LEN_W+1)'(1)) >> 1;
  end

  always_comb begin
    case (strobe.sel)
      SEL_RDCMD:  txByte = {2'b10, LEN_REG_ADDR};
      SEL_WRCMD:  txByte = {2'b00, LEN_REG_ADDR};
      SEL_RAMCMD: txByte = {2'b00, RAM_ADDR};
      SEL_REGHI:  txByte = newReg[15:8];
      SEL_REGLO:  txByte = newReg[7:0];
      SEL_BUFHI:  txByte = padHi ? 8'h00 : bufData;
      SEL_BUFLO:  txByte = bufData;
      default:    txByte = 8'h00;
    endcase
  end

  // Frame bookkeeping: latched length, word index, captured register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenR    <= '0;
      wordIdx <= '0;
      regWord <= '0;
      csNR    <= 1'b1;
    end else begin
      if (strobe.latchLen) lenR <= frameLen;
      if (strobe.clrWord) wordIdx <= '0;
      else if (strobe.nextWord) wordIdx <= wordIdx + IDX_W'(1);
      if (strobe.capHi) regWord[15:8] <= rxSh;
      if (strobe.capLo) regWord[7:0] <= rxSh;
      if (strobe.ceOn) csNR <= 1'b0;
      else if (strobe.ceOff) csNR <= 1'b1;
    end
  end

  // SCLK half-period tick: the parameter picks a counter or a constant
  generate
    if (HALF_DIV == 1) begin : gNoDiv
      assign halfTick = 1'b1;
    end else begin : gDiv
      localparam int HCW = $clog2(HALF_DIV);
      localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_DIV - 1);
      logic [HCW-1:0] halfCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) halfCnt <= '0;
        else if (strobe.startByte || !byteBusy || halfCnt == HALF_LAST) halfCnt <= '0;
        else halfCnt <= halfCnt + HCW'(1);
      end
      assign halfTick = (halfCnt == HALF_LAST);
    end
  endgenerate

  // Byte serializer: 16 half periods, sample on rise, shift on fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkR     <= 1'b0;
      edgeCnt   <= '0;
      txSh      <= '0;
      rxSh      <= '0;
      byteBusy  <= 1'b0;
      byteDoneR <= 1'b0;
    end else begin
      byteDoneR <= 1'b0;
      if (strobe.startByte) begin
        txSh     <= txByte;
        byteBusy <= 1'b1;
        edgeCnt  <= '0;
      end else if (byteBusy && halfTick) begin
        sclkR   <= ~sclkR;
        edgeCnt <= edgeCnt + 4'd1;
        if (!sclkR) rxSh <= {rxSh[6:0], spiMiso};
        else txSh <= {txSh[6:0], 1'b0};
        if (edgeCnt == 4'd15) begin
          byteBusy  <= 1'b0;
          byteDoneR <= 1'b1;
        end
      end
    end
  end

  assign spiCsN  = csNR;
  assign spiClk  = sclkR;
  assign spiMosi = byteBusy ? txSh[7] : 1'b0;

  assign status.byteDone   = byteDoneR;
  assign status.lastWord   = ((LEN_W+1)'(wordIdx) + (LEN_W+1)'(1)) == wordsTotal;
  assign status.emptyFrame = (lenR == '0);

endmodule

// File: rtl/txLoaderControl.sv
module txLoaderControl
  import txLoaderPkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GW = $clog2(GAP_CYC + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RDCMD, ST_RDHI, ST_RDLO, ST_GAPA,
    ST_WRCMD, ST_WRHI, ST_WRLO, ST_GAPB,
    ST_RAMCMD, ST_DATHI, ST_DATLO, ST_FIN
  } state_e;

  state_e        state, nxt;
  logic [GW-1:0] gapCnt;
  logic          gapLoad;
  logic          gapDec;

  always_comb begin
    strobe  = '0;
    strobe.sel = SEL_DUMMY;
    nxt     = state;
    gapLoad = 1'b0;
    gapDec  = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        strobe.latchLen  = 1'b1;
        strobe.clrWord   = 1'b1;
        strobe.ceOn      = 1'b1;
        strobe.startByte = 1'b1;
        strobe.sel       = SEL_RDCMD;
        nxt = ST_RDCMD;
      end
      ST_RDCMD: if (status.byteDone) begin
        strobe.startByte = 1'b1;
        nxt = ST_RDHI;
      end
      ST_RDHI: if (status.byteDone) begin
        strobe.capHi     = 1'b1;
        strobe.startByte = 1'b1;
        nxt = ST_RDLO;
      end
      ST_RDLO: if (status.byteDone) begin
        strobe.capLo = 1'b1;
        strobe.ceOff = 1'b1;
        gapLoad = 1'b1;
        nxt = ST_GAPA;
      end
      ST_GAPA: if (gapCnt == '0) begin
        strobe.ceOn      = 1'b1;
        strobe.startByte = 1'b1;
        strobe.sel       = SEL_WRCMD;
        nxt = ST_WRCMD;
      end else gapDec = 1'b1;
      ST_WRCMD: if (status.byteDone) begin
        strobe.startByte = 1'b1;
        strobe.sel       = SEL_REGHI;
        nxt = ST_WRHI;
      end
      ST_WRHI: if (status.byteDone) begin
        strobe.startByte = 1'b1;
        strobe.sel       = SEL_REGLO;
        nxt = ST_WRLO;
      end
      ST_WRLO: if (status.byteDone) begin
        strobe.ceOff = 1'b1;
        gapLoad = 1'b1;
        nxt = ST_GAPB;
      end
      ST_GAPB: if (gapCnt == '0) begin
        strobe.ceOn      = 1'b1;
        strobe.startByte = 1'b1;
        strobe.sel       = SEL_RAMCMD;
        nxt = ST_RAMCMD;
      end else gapDec = 1'b1;
      ST_RAMCMD: if (status.byteDone) begin
        if (status.emptyFrame) begin
          strobe.ceOff = 1'b1;
          nxt = ST_FIN;
        end else begin
          strobe.startByte = 1'b1;
          strobe.sel       = SEL_BUFHI;
          nxt = ST_DATHI;
        end
      end
      ST_DATHI: if (status.byteDone) begin
        strobe.startByte = 1'b1;
        strobe.sel       = SEL_BUFLO;
        nxt = ST_DATLO;
      end
      ST_DATLO: if (status.byteDone) begin
        if (status.lastWord) begin
          strobe.ceOff = 1'b1;
          nxt = ST_FIN;
        end else begin
          strobe.nextWord  = 1'b1;
          strobe.startByte = 1'b1;
          strobe.sel       = SEL_BUFHI;
          nxt = ST_DATHI;
        end
      end
      ST_FIN: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      state <= nxt;
      if (gapLoad) gapCnt <= GW'(GAP_CYC - 1);
      else if (gapDec) gapCnt <= gapCnt - GW'(1);
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/txFrameLoader.sv
module txFrameLoader #(
  parameter int HALF_DIV = 2,
  parameter int LEN_W = 7,
  parameter logic [5:0] LEN_REG_ADDR = 6'h03,
  parameter logic [5:0] RAM_ADDR = 6'h02
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] frameLen,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] bufAddr,
  input  logic [7:0]       bufData,
  output logic             spiCsN,
  output logic             spiClk,
  output logic             spiMosi,
  input  logic             spiMiso
);

  txLoaderPkg::ctrlStrobe_t strobe;
  txLoaderPkg::dpStatus_t   status;

  txLoaderControl #(.HALF_DIV(HALF_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .status(status),
    .strobe(strobe), .busy(busy), .done(done)
  );

  txLoaderDatapath #(
    .HALF_DIV(HALF_DIV), .LEN_W(LEN_W),
    .LEN_REG_ADDR(LEN_REG_ADDR), .RAM_ADDR(RAM_ADDR)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameLen(frameLen),
    .status(status), .bufAddr(bufAddr), .bufData(bufData),
    .spiCsN(spiCsN), .spiClk(spiClk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

endmodule

// File: rtl/txFrameLoaderChecker.sv
module txFrameLoaderChecker #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic spiCsN,
  input logic spiClk,
  input logic spiMosi
);

  localparam logic [15:0] GAP_CYC = 16'(2 * HALF_DIV);

  logic [15:0] highCnt;
  logic        inRun;

  // Cycles spent with CE high, and whether a frame of this run happened
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
      inRun   <= 1'b0;
    end else begin
      if (!spiCsN) highCnt <= '0;
      else if (highCnt != 16'hFFFF) highCnt <= highCnt + 16'd1;
      if (done) inRun <= 1'b0;
      else if (!spiCsN) inRun <= 1'b1;
    end
  end

  assert_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(spiCsN) && inRun) |-> (highCnt >= GAP_CYC));

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiClk);

  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiClk) |-> $stable(spiMosi));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_done_ce_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (spiCsN && busy));

  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (spiCsN && !spiClk));

endmodule

bind txFrameLoader txFrameLoaderChecker #(.HALF_DIV(HALF_DIV)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .spiCsN(spiCsN), .spiClk(spiClk), .spiMosi(spiMosi)
);

// File: tb/txFrameLoader_test.sv
module txFrameLoader_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam logic [7:0] RD_CMD = 8'h83;
  localparam logic [7:0] WR_CMD = 8'h03;
  localparam logic [7:0] RAM_CMD = 8'h02;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [6:0] frameLen = '0;
  logic       busy, done;
  logic [6:0] bufAddr;
  logic [7:0] bufData;
  logic       spiCsN, spiClk, spiMosi;
  logic       spiMiso = 1'b0;

  logic [7:0] mem [0:127];
  assign bufData = mem[bufAddr];

  int checks = 0;
  int errors = 0;

  // Scoreboard queues: expected bytes with a tag, expected frame sizes
  logic [7:0] expByteQ[$];
  string      expTagQ[$];
  int         expLenQ[$];

  logic [15:0] slaveReg;
  int          sclkBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txFrameLoader uut (
    .clk(clk), .rstN(rstN), .start(start), .frameLen(frameLen),
    .busy(busy), .done(done), .bufAddr(bufAddr), .bufData(bufData),
    .spiCsN(spiCsN), .spiClk(spiClk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Slave model: mode 0, answers the length-register read
  int         sBit = 0;
  int         sByte = 0;
  logic [7:0] sRx = '0;
  logic [7:0] sCmd = '0;
  logic [7:0] sOut = '0;

  always @(negedge spiCsN) begin
    sBit = 0; sByte = 0; sCmd = '0; sOut = 8'h00;
    spiMiso = sOut[7];
  end

  always @(posedge spiClk) begin
    if (!spiCsN) begin
      sRx = {sRx[6:0], spiMosi};
      sBit++;
      if (sBit == 8) begin
        sBit = 0;
        if (expByteQ.size() == 0) begin
          check(0, "R9", "unexpected byte", sRx, 0);
        end else begin
          automatic logic [7:0] e = expByteQ.pop_front();
          automatic string t = expTagQ.pop_front();
          check(sRx == e, t, "byte", sRx, e);
        end
        if (sByte == 0) sCmd = sRx;
        sByte++;
        if (sCmd == RD_CMD) sOut = (sByte == 1) ? slaveReg[15:8] :
                                   (sByte == 2) ? slaveReg[7:0] : 8'h00;
        else sOut = 8'hA5;
      end
    end
  end

  always @(negedge spiClk) begin
    if (!spiCsN) spiMiso = sOut[7 - sBit];
  end

  // Monitor: frame sizes at every CE rise
  always @(posedge spiCsN) begin
    if (rstN) begin
      if (expLenQ.size() == 0) begin
        check(0, "R9", "unexpected frame", sByte, 0);
      end else begin
        automatic int e = expLenQ.pop_front();
        check(sByte == e && sBit == 0, "R5", "frame byte count", sByte, e);
      end
    end
  end

  // Gap between frames and SCLK idle, sampled between edges
  int  hc = 0;
  int  runFrames = 0;
  logic prevCs = 1'b1;
  always @(negedge clk) begin
    if (spiCsN && spiClk) sclkBad++;
    if (!busy) begin
      hc = 0; runFrames = 0;
    end else if (spiCsN) begin
      hc++;
    end else if (prevCs) begin
      if (runFrames > 0) check(hc >= 2*HALF, "R4", "CE high gap", hc, 2*HALF);
      runFrames++;
      hc = 0;
    end
    prevCs = spiCsN;
  end

  task automatic pushByte(input logic [7:0] b, input string tag);
    expByteQ.push_back(b);
    expTagQ.push_back(tag);
  endtask

  // Driver: fill the buffer, queue expectations, run one transaction
  task automatic runFrame(input int len, input logic [15:0] oldReg,
                          input int seed, input bit interfere);
    int words;
    logic [15:0] newReg;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i*7 + seed*13 + 1);
    slaveReg = oldReg;
    words = (len + 1) / 2;
    newReg = (oldReg & 16'hFF80) | 16'((len + 2) & 7'h7F);
    pushByte(RD_CMD, "R1"); pushByte(8'h00, "R2"); pushByte(8'h00, "R2");
    expLenQ.push_back(3);
    pushByte(WR_CMD, "R1"); pushByte(newReg[15:8], "R3"); pushByte(newReg[7:0], "R3");
    expLenQ.push_back(3);
    pushByte(RAM_CMD, "R1");
    for (int k = 0; k < words; k++) begin
      if (2*k + 1 < len) pushByte(mem[2*k+1], "R6");
      else pushByte(8'h00, "R7");
      pushByte(mem[2*k], "R6");
    end
    expLenQ.push_back(1 + 2*words);
    sclkBad = 0;

    @(negedge clk);
    start = 1'b1; frameLen = 7'(len);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (interfere) begin
      repeat (60) @(negedge clk);
      frameLen = 7'(len + 5);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(spiCsN == 1'b1, "R10", "CE high at done", spiCsN, 1);
    @(negedge clk);
    check(done == 1'b0, "R10", "done width", done, 0);
    check(busy == 1'b0, "R10", "busy after done", busy, 0);
    repeat (64*HALF) @(negedge clk);
    check(spiCsN == 1'b1 && !busy, "R9", "no extra activity", spiCsN, 1);
    check(expByteQ.size() == 0 && expLenQ.size() == 0, "R5", "all frames seen",
          expByteQ.size() + expLenQ.size(), 0);
    check(sclkBad == 0, "R8", "SCLK high with CE high", sclkBad, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    slaveReg = '0;
    repeat (3) @(negedge clk);
    check(spiCsN == 1'b1, "R11", "reset CE", spiCsN, 1);
    check(spiClk == 1'b0, "R11", "reset SCLK", spiClk, 0);
    check(busy == 1'b0 && done == 1'b0, "R11", "reset busy/done", {busy, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(spiCsN == 1'b1 && spiMosi == 1'b0, "R11", "idle pins", {spiCsN, spiMosi}, 2);
    runFrame(0,   16'h1234, 1, 0);
    runFrame(1,   16'hFFFF, 2, 0);
    runFrame(2,   16'h0000, 3, 0);
    runFrame(5,   16'hABCD, 4, 0);
    runFrame(8,   16'h5A80, 5, 0);
    runFrame(4,   16'hC37F, 6, 1);
    runFrame(126, 16'h00FF, 7, 0);
    runFrame(127, 16'h7F7F, 8, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule